// File: doc/BRIEF.md
# Case-Converting Text Buffer Engine

This block is a small memory-mapped accelerator that sits behind two base address registers owned by a neighbouring configuration block. The first register places a one-byte I/O window that holds the operation selector. The second places a 256-byte memory window over a text buffer that the host reads and writes one byte at a time. Each window's base is the register value with bit 0 (the space indicator) cleared. An address hits a window when it is at or above the base and below the base plus the window size. The offset into the window is the address minus the base.

To transform text, the host writes bytes into the buffer, picks an operation, and then commits a region by giving its absolute start address and a length. The engine latches the operation and rewrites the region in place, one byte per clock. It raises `busy` for the whole run and then pulses `done` for one cycle. A region that runs past the end of the buffer is clipped at the end. A start address outside the buffer window gives an empty region.

Top module: `tcx_engine`

## Requirements
- R1: An I/O access hits only when `bar0Base & ~1 <= ioAddr < (bar0Base & ~1) + 1`. A memory access hits only when `bar1Base & ~1 <= memAddr < (bar1Base & ~1) + 256`. `ioMiss` or `memMiss` is 1 while a valid access hits no window. A memory read that hits returns the byte at offset `memAddr - base`.
- R2: A write that misses its window changes neither the operation register nor any buffer byte.
- R3: A read that hits the operation register returns `{ioPass[31:8], op[7:0]}`. Any other read returns `ioPass` unchanged. The operation register resets to 0.
- R4: A memory write that hits stores `memWdata` at its offset. A later read of that offset returns it. The buffer resets to all zeros.
- R5: Operation 0 turns each byte 0x41..0x5A into the same byte with bit 5 set. Every other byte is left as it is.
- R6: Operation 1 turns each byte 0x61..0x7A into the same byte with bit 5 cleared. Every other byte is left as it is.
- R7: Operation 2 toggles bit 5 of every ASCII letter (0x41..0x5A and 0x61..0x7A). Every other byte is left as it is.
- R8: An operation value of 3 to 255 leaves every byte unchanged.
- R9: A committed region holds min(`commitLen`, 256 − offset) bytes, starting at the offset. Bytes outside the region are left as they are.
- R10: A commit whose start address misses the buffer window has length 0. `busy` stays low, `done` pulses in the next cycle, and no byte changes. A hit with `commitLen` 0 behaves the same way.
- R11: A commit of effective length L > 0 that is sampled at clock edge e keeps `busy` high for exactly L cycles after e. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R12: A commit presented while `busy` is high is ignored. The running region and its length are unaffected.
- R13: The operation is latched when a commit is accepted. Writing the operation register while the engine is busy does not change the bytes of the run already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bar0Base | input | 32 | I/O window base register value (bit 0 ignored) |
| bar1Base | input | 32 | Memory window base register value (bit 0 ignored) |
| ioValid | input | 1 | I/O access strobe |
| ioWrite | input | 1 | I/O access is a write |
| ioAddr | input | 32 | I/O access address |
| ioWdata | input | 32 | I/O write data (low byte used) |
| ioPass | input | 32 | Incoming read word whose upper bits are kept |
| ioRdata | output | 32 | I/O read word |
| ioMiss | output | 1 | I/O access hit no window |
| memValid | input | 1 | Buffer access strobe |
| memWrite | input | 1 | Buffer access is a write |
| memAddr | input | 32 | Buffer access address |
| memWdata | input | 8 | Buffer write byte |
| memRdata | output | 8 | Buffer read byte (combinational) |
| memMiss | output | 1 | Buffer access hit no window |
| commitValid | input | 1 | Commit request strobe |
| commitAddr | input | 32 | Absolute start address of the region |
| commitLen | input | 10 | Requested region length |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the window edges. It probes one byte below each base, the last byte inside each window, and the first byte past it. A comparator that is off by one would flag a valid byte as a miss, or let a stray write corrupt byte 0 or byte 255. Regions that cross the end of the buffer, and starts beyond it, must shorten the run. An unclipped run would wrap around and rewrite the start of the buffer, which the bench sees as a wrong `busy` length. Non-letter bytes next to the letter ranges ('@', '[', '`', '{') catch range checks that are too wide. A commit injected mid-run and an operation change mid-run show up as extra changed bytes or a stretched busy period if the engine reacts to either.

// File: rtl/tcx_pkg.sv
`timescale 1ns/1ps
package tcx_pkg;

  localparam logic [7:0] OP_LOWER = 8'd0;
  localparam logic [7:0] OP_UPPER = 8'd1;
  localparam logic [7:0] OP_SWAP  = 8'd2;

  localparam logic [7:0] CASE_BIT = 8'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;   // capture operation register at commit acceptance
    logic xformEn;  // rewrite one byte this cycle
  } ctlStrobe_t;

  function automatic logic isUpperAscii(input logic [7:0] b);
    return (b >= 8'h41) && (b <= 8'h5A);
  endfunction

  function automatic logic isLowerAscii(input logic [7:0] b);
    return (b >= 8'h61) && (b <= 8'h7A);
  endfunction

  function automatic logic [7:0] xformByte(input logic [7:0] b, input logic [7:0] op);
    logic [7:0] r;
    r = b;
    case (op)
      OP_LOWER: if (isUpperAscii(b)) r = b | CASE_BIT;
      OP_UPPER: if (isLowerAscii(b)) r = b & ~CASE_BIT;
      OP_SWAP: begin
        if (isUpperAscii(b))      r = b | CASE_BIT;
        else if (isLowerAscii(b)) r = b & ~CASE_BIT;
      end
      default: r = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tcx_window.sv
`timescale 1ns/1ps
module tcx_window #(
  parameter int ADDR_W = 32,
  parameter int SPAN   = 256
) (
  input  logic [ADDR_W-1:0] barVal,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(SPAN);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   baseX;
  logic [ADDR_W:0]   addrX;
  logic [ADDR_W:0]   limitX;

  always_comb begin
    base   = barVal & ~{{(ADDR_W-1){1'b0}}, 1'b1};
    baseX  = {1'b0, base};
    addrX  = {1'b0, addr};
    limitX = baseX + SPAN_X;
    hit    = (addrX >= baseX) && (addrX < limitX);
    offset = addr - base;
  end
endmodule

// File: rtl/tcx_ctrl.sv
`timescale 1ns/1ps
module tcx_ctrl
  import tcx_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int LEN_W     = 10,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             commitValid,
  input  logic             commitHit,
  input  logic [IDX_W-1:0] commitOff,
  input  logic [LEN_W-1:0] commitLen,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] xIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

  logic             busyQ;
  logic             doneQ;
  logic [IDX_W-1:0] idxQ;
  logic [LEN_W-1:0] remainQ;
  logic [LEN_W-1:0] avail;
  logic [LEN_W-1:0] effLen;
  logic             accept;

  always_comb begin
    avail  = BUF_LEN - LEN_W'(commitOff);
    if (!commitHit)            effLen = '0;
    else if (commitLen < avail) effLen = commitLen;
    else                        effLen = avail;
    accept = commitValid && !busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      idxQ    <= '0;
      remainQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (accept) begin
          idxQ    <= commitOff;
          remainQ <= effLen;
          if (effLen == '0) doneQ <= 1'b1;
          else              busyQ <= 1'b1;
        end
      end else begin
        idxQ    <= idxQ + 1'b1;
        remainQ <= remainQ - 1'b1;
        if (remainQ == LEN_W'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign strobe.loadOp  = accept;
  assign strobe.xformEn = busyQ;
  assign xIdx           = idxQ;
  assign busy           = busyQ;
  assign done           = doneQ;
endmodule

// File: rtl/tcx_datapath.sv
`timescale 1ns/1ps
module tcx_datapath
  import tcx_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [IDX_W-1:0] xIdx,
  input  logic             opWe,
  input  logic [7:0]       opWbyte,
  input  logic             memWe,
  input  logic [IDX_W-1:0] memIdx,
  input  logic [7:0]       memWbyte,
  output logic [7:0]       opVal,
  output logic [7:0]       memRbyte
);
  logic [7:0] textBuf [BUF_BYTES];
  logic [7:0] opQ;
  logic [7:0] opRunQ;
  logic [7:0] xNext;

  always_comb xNext = xformByte(textBuf[xIdx], opRunQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= OP_LOWER;
      opRunQ <= OP_LOWER;
    end else begin
      if (opWe)          opQ    <= opWbyte;
      if (strobe.loadOp) opRunQ <= opQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) textBuf[i] <= 8'h00;
    end else begin
      if (strobe.xformEn) textBuf[xIdx] <= xNext;
      if (memWe)          textBuf[memIdx] <= memWbyte;
    end
  end

  assign opVal    = opQ;
  assign memRbyte = textBuf[memIdx];
endmodule

// File: rtl/tcx_engine.sv
`timescale 1ns/1ps
module tcx_engine
  import tcx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 256,
  parameter int IO_BYTES  = 1,
  parameter int LEN_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] bar0Base,
  input  logic [ADDR_W-1:0] bar1Base,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [31:0]       ioWdata,
  input  logic [31:0]       ioPass,
  output logic [31:0]       ioRdata,
  output logic              ioMiss,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWdata,
  output logic [7:0]        memRdata,
  output logic              memMiss,
  input  logic              commitValid,
  input  logic [ADDR_W-1:0] commitAddr,
  input  logic [LEN_W-1:0]  commitLen,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = $clog2(BUF_BYTES);

  logic              ioHit, memHit, cmHit;
  logic [ADDR_W-1:0] ioOff, memOff, cmOff;
  logic [7:0]        opVal, memRbyte;
  logic [IDX_W-1:0]  xIdx;
  ctlStrobe_t        strobe;

  tcx_window #(.ADDR_W(ADDR_W), .SPAN(IO_BYTES)) ioWin_i (
    .barVal(bar0Base), .addr(ioAddr), .hit(ioHit), .offset(ioOff));
  tcx_window #(.ADDR_W(ADDR_W), .SPAN(BUF_BYTES)) memWin_i (
    .barVal(bar1Base), .addr(memAddr), .hit(memHit), .offset(memOff));
  tcx_window #(.ADDR_W(ADDR_W), .SPAN(BUF_BYTES)) cmWin_i (
    .barVal(bar1Base), .addr(commitAddr), .hit(cmHit), .offset(cmOff));

  tcx_ctrl #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) ctl_i (
    .clk(clk), .rstN(rstN), .commitValid(commitValid), .commitHit(cmHit),
    .commitOff(cmOff[IDX_W-1:0]), .commitLen(commitLen),
    .strobe(strobe), .xIdx(xIdx), .busy(busy), .done(done));

  tcx_datapath #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .xIdx(xIdx),
    .opWe(ioValid && ioWrite && ioHit && (ioOff == '0)), .opWbyte(ioWdata[7:0]),
    .memWe(memValid && memWrite && memHit), .memIdx(memOff[IDX_W-1:0]),
    .memWbyte(memWdata), .opVal(opVal), .memRbyte(memRbyte));

  always_comb begin
    ioMiss   = ioValid && !ioHit;
    memMiss  = memValid && !memHit;
    ioRdata  = (ioValid && ioHit && (ioOff == '0)) ? {ioPass[31:8], opVal} : ioPass;
    memRdata = (memValid && memHit) ? memRbyte : 8'h00;
  end
endmodule

// File: rtl/tcx_checker.sv
`timescale 1ns/1ps
module tcx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ioValid,
  input logic        ioWrite,
  input logic        ioMiss,
  input logic [31:0] ioPass,
  input logic [31:0] ioRdata,
  input logic [7:0]  opVal,
  input logic        commitValid,
  input logic        cmHit,
  input logic        busy,
  input logic        done
);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_end_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_miss_keeps_op_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && ioWrite && ioMiss) |=> $stable(opVal));

  assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && !ioWrite) |-> (ioRdata[31:8] == ioPass[31:8]));

  assert_empty_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !busy && !done && !cmHit) |=> (done && !busy));
endmodule

bind tcx_engine tcx_checker chk_i (
  .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite), .ioMiss(ioMiss),
  .ioPass(ioPass), .ioRdata(ioRdata), .opVal(opVal), .commitValid(commitValid),
  .cmHit(cmHit), .busy(busy), .done(done));

// File: tb/tcx_engine_tb.sv
`timescale 1ns/1ps
module tcx_engine_tb_top;
  localparam logic [31:0] B0 = 32'h0000_C001;
  localparam logic [31:0] B1 = 32'h0004_0000;

  logic clk = 0;
  logic rstN = 0;
  logic ioValid = 0, ioWrite = 0, memValid = 0, memWrite = 0, commitValid = 0;
  logic [31:0] ioAddr = 0, ioWdata = 0, ioPass = 0, memAddr = 0, commitAddr = 0;
  logic [7:0] memWdata = 0;
  logic [9:0] commitLen = 0;
  logic [31:0] ioRdata;
  logic [7:0] memRdata;
  logic ioMiss, memMiss, busy, done;

  int total = 0, bad = 0;
  logic [7:0] model [256];
  logic [7:0] opModel = 0;

  always #5 clk = ~clk;

  tcx_engine dut_i (
    .clk(clk), .rstN(rstN), .bar0Base(B0), .bar1Base(B1),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioPass(ioPass), .ioRdata(ioRdata), .ioMiss(ioMiss),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memMiss(memMiss),
    .commitValid(commitValid), .commitAddr(commitAddr), .commitLen(commitLen),
    .busy(busy), .done(done));

  function automatic logic [7:0] refXf(input logic [7:0] b, input logic [7:0] op);
    logic up, lo;
    up = (b >= "A") && (b <= "Z");
    lo = (b >= "a") && (b <= "z");
    if (op == 0 && up) return b + 8'd32;
    if (op == 1 && lo) return b - 8'd32;
    if (op == 2 && up) return b + 8'd32;
    if (op == 2 && lo) return b - 8'd32;
    return b;
  endfunction

  function automatic int effLen(input logic [31:0] a, input int len);
    longint off;
    off = longint'(a) - longint'(B1 & ~32'h1);
    if (off < 0 || off >= 256) return 0;
    return (len < 256 - off) ? len : int'(256 - off);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ioWr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ioValid = 1; ioWrite = 1; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioValid = 0; ioWrite = 0;
  endtask

  task automatic ioRd(input logic [31:0] a, input logic [31:0] pass,
                      output logic [31:0] d, output logic m);
    @(negedge clk);
    ioValid = 1; ioWrite = 0; ioAddr = a; ioPass = pass;
    #1; d = ioRdata; m = ioMiss;
    #1; ioValid = 0;
  endtask

  task automatic memWr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    memValid = 1; memWrite = 1; memAddr = a; memWdata = d;
    @(negedge clk);
    memValid = 0; memWrite = 0;
  endtask

  task automatic memRd(input logic [31:0] a, output logic [7:0] d, output logic m);
    @(negedge clk);
    memValid = 1; memWrite = 0; memAddr = a;
    #1; d = memRdata; m = memMiss;
    #1; memValid = 0;
  endtask

  task automatic setOp(input logic [7:0] op);
    ioWr(B0 & ~32'h1, {24'hABCDEF, op});
    opModel = op;
  endtask

  // commit and measure; optionally inject a second commit or op change mid-run
  task automatic runCommit(input logic [31:0] a, input int len, input string tag,
                           input logic injCommit, input logic injOp);
    int exp, busyCnt, off;
    logic [7:0] runOp;
    exp = effLen(a, len);
    runOp = opModel;
    @(negedge clk);
    commitValid = 1; commitAddr = a; commitLen = 10'(len);
    @(negedge clk);
    commitValid = 0;
    busyCnt = 0;
    for (int k = 0; k < 400; k++) begin
      if (done) break;
      if (busy) busyCnt++;
      if (busyCnt == 2 && injCommit) begin
        commitValid = 1; commitAddr = B1; commitLen = 10'd5;
      end else begin
        commitValid = 0;
      end
      if (busyCnt == 2 && injOp) begin
        ioValid = 1; ioWrite = 1; ioAddr = B0 & ~32'h1; ioWdata = 32'd3;
        opModel = 8'd3;
      end else begin
        ioValid = 0; ioWrite = 0;
      end
      @(negedge clk);
    end
    commitValid = 0; ioValid = 0; ioWrite = 0;
    chk(busyCnt == exp, {tag, " R11 busy length"}, busyCnt, exp);
    chk(done && !busy, {tag, " R11 done with busy low"}, {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, {tag, " R11 done one cycle"}, done, 0);
    off = int'(a - (B1 & ~32'h1));
    for (int i = 0; i < exp; i++) model[off + i] = refXf(model[off + i], runOp);
  endtask

  task automatic compareAll(input string tag);
    int mis, firstI;
    logic [7:0] d, fb;
    logic m;
    mis = 0; firstI = -1; fb = 0;
    for (int i = 0; i < 256; i++) begin
      memRd(B1 + i, d, m);
      if (d !== model[i] || m) begin
        mis++;
        if (firstI < 0) begin firstI = i; fb = d; end
      end
    end
    if (firstI < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, $sformatf(" byte %0d (%0d bad)", firstI, mis)}, fb, model[firstI]);
  endtask

  task automatic fillStr(input int off, input string s);
    for (int i = 0; i < s.len(); i++) begin
      memWr(B1 + off + i, s[i]);
      model[off + i] = s[i];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] b;
    logic m;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    @(negedge clk);
    chk(!busy && !done, "R11 reset idle", {busy, done}, 0);
    ioRd(32'h0000_C000, 32'hAABBCC55, rd, m);
    chk(rd == 32'hAABBCC00 && !m, "R3 reset op read", rd, 32'hAABBCC00);
    memRd(B1 + 5, b, m);
    chk(b == 0 && !m, "R4 reset buffer", b, 0);

    // window edges
    ioRd(32'h0000_C001, 32'h1234_5678, rd, m);
    chk(m && rd == 32'h1234_5678, "R1 io past end miss", {m, rd}, {1'b1, 32'h12345678});
    ioRd(32'h0000_BFFF, 32'h0, rd, m);
    chk(m, "R1 io below base miss", m, 1);
    memRd(B1 + 256, b, m);
    chk(m, "R1 mem past end miss", m, 1);
    memRd(B1 - 1, b, m);
    chk(m, "R1 mem below base miss", m, 1);
    memRd(B1 + 255, b, m);
    chk(!m, "R1 mem last byte hit", m, 0);

    // missed writes have no effect
    ioWr(32'h0000_C001, 32'h2);
    ioRd(32'h0000_C000, 32'h0, rd, m);
    chk(rd[7:0] == 0, "R2 io miss write ignored", rd[7:0], 0);
    memWr(B1 + 256, 8'h77);
    memWr(B1 - 1, 8'h66);
    memRd(B1 + 0, b, m);
    chk(b == 0, "R2 mem miss write byte0", b, 0);
    memRd(B1 + 255, b, m);
    chk(b == 0, "R2 mem miss write byte255", b, 0);

    // op register write/read
    setOp(8'h2);
    ioRd(32'h0000_C000, 32'hFFFF_FFFF, rd, m);
    chk(rd == 32'hFFFF_FF02, "R3 op read merge", rd, 32'hFFFFFF02);

    // directed transforms
    fillStr(0, "@AZ[`az{ Hi, 09!");
    compareAll("R4 buffer write/read");
    setOp(8'd0); runCommit(B1, 17, "R5", 0, 0); compareAll("R5 lower");
    fillStr(0, "@AZ[`az{ Hi, 09!");
    setOp(8'd1); runCommit(B1, 17, "R6", 0, 0); compareAll("R6 upper");
    fillStr(0, "@AZ[`az{ Hi, 09!");
    setOp(8'd2); runCommit(B1, 17, "R7", 0, 0); compareAll("R7 swap");
    setOp(8'd3); runCommit(B1, 17, "R8", 0, 0); compareAll("R8 op3 unchanged");
    setOp(8'd200); runCommit(B1, 17, "R8", 0, 0); compareAll("R8 op200 unchanged");

    // clipping at the end
    fillStr(246, "abcdefghij");
    setOp(8'd1); runCommit(B1 + 250, 20, "R9", 0, 0); compareAll("R9 clipped region");
    runCommit(B1 + 240, 3, "R9", 0, 0); compareAll("R9 short inner region");

    // empty commits
    runCommit(B1 + 256, 10, "R10", 0, 0); compareAll("R10 miss commit");
    runCommit(B1 - 4, 10, "R10", 0, 0); compareAll("R10 below commit");
    runCommit(B1 + 3, 0, "R10", 0, 0); compareAll("R10 zero length");

    // commit during busy ignored
    fillStr(0, "Mixed Case TEXT here");
    setOp(8'd2); runCommit(B1 + 8, 12, "R12", 1, 0); compareAll("R12 inner commit ignored");

    // op change mid-run does not affect the run
    fillStr(30, "lower text run");
    setOp(8'd1); runCommit(B1 + 30, 14, "R13", 0, 1); compareAll("R13 op latched");
    ioRd(32'h0000_C000, 32'h0, rd, m);
    chk(rd[7:0] == 3, "R13 op register updated", rd[7:0], 3);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int nb, len;
      logic [31:0] a;
      nb = 4 + int'($urandom % 12);
      for (int j = 0; j < nb; j++) begin
        int o;
        logic [7:0] v;
        o = int'($urandom % 256);
        v = 8'($urandom % 128);
        memWr(B1 + o, v);
        model[o] = v;
      end
      setOp(8'($urandom % 5));
      a = B1 + ($urandom % 300) - 8;
      len = int'($urandom % 300);
      runCommit(a, len, "R9 random", 0, 0);
      compareAll($sformatf("R9 random iter %0d", it));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule